// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer Register Block

This block sits between software and one shared 12-bit converter that serves 16 input channels. Software arms a channel by writing its request bit from 0 to 1. The block queues the armed channels and hands them to the converter one at a time. For each conversion it drives a one-cycle start pulse with the channel number, waits for the converter's done strobe, and stores the result together with a ready flag in that channel's data word.

Software reads a global busy bit to see whether any work is queued or running. A power-enable bit holds all new conversions back while it is low. Clearing a request bit withdraws the channel. Its ready flag drops at once, a queued conversion for it is dropped, and a conversion already running for it is discarded when it finishes.

The register port is a plain 32-bit word interface. A write is taken on any clock edge where the write enable is high. Read data follows the address combinationally. The register offsets are fixed: 0x00 holds a general control word, 0x04 holds the request bits, 0x10 holds the status, 0x14 plus 4·n is the data word for channel n, and 0x94 holds the power register.

Top module: `adc_seq_regs`

## Requirements
- R1: After reset, every register reads 0 and `conv_start_o` is low.
- R2: A write to 0x04 that takes bit n from 0 to 1 starts a conversion on channel n. With power on and the block idle, `conv_start_o` is high for exactly one cycle, with `conv_ch_o` = n. That cycle is the second cycle after the write edge.
- R3: When `conv_done_i` is taken during a live conversion, the word at 0x14+4·n reads `conv_res_i` in bits 11:0 and 1 in bit 12 (the ready flag) from the next cycle on. The ready flag never sets without a done strobe.
- R4: Channels armed together are converted one at a time, lowest channel number first.
- R5: A write to 0x04 that takes bit n from 1 to 0 clears bit 12 of channel n's data word in the next cycle. Bits 11:0 keep their old value.
- R6: A channel whose request bit is cleared before its conversion starts is never started.
- R7: A channel whose request bit is cleared while its conversion is running keeps ready at 0, and its stored result is left unchanged when done arrives.
- R8: Bit 0 of 0x10 reads 1 while any channel is queued or being converted, and reads 0 otherwise.
- R9: While bit 14 of 0x94 is 0, no conversion starts. Queued channels start once the bit is set.
- R10: Writes to 0x10 and to the data words are ignored. Rewriting a request bit that is already 1 starts nothing.
- R11: 0x00 reads back all 32 written bits. 0x04 reads back bits 15:0. 0x94 reads back bit 14 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_ch_o | output | 4 | Channel being converted |
| conv_done_i | input | 1 | Converter result valid strobe |
| conv_res_i | input | 12 | Converter result |

## Verification
The busy bit rises in the first cycle after the write edge that arms a channel. The start pulse follows one cycle later, so the bench samples both at the negative edges that fall in those two cycles. A stored result and its ready flag appear in the cycle after the edge where done is taken, and the busy bit drops at that same edge. For this reason the bench polls status until it reads idle and only then reads the data words. A cleared ready flag is read in the cycle after the clearing write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned NUM_CH  = 16;
  localparam int unsigned RES_W   = 12;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned PWR_BIT = 14;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_REQ  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_DATA = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_PWR  = 8'h94;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BUSY} seq_state_e;
endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
  parameter int unsigned N = 16,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
  assign valid_o = |vec_i;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_CH = 16,
  parameter int unsigned CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_en_i,
  input  logic [N_CH-1:0] avail_i,
  input  logic [N_CH-1:0] cancel_i,
  input  logic            conv_done_i,
  output logic            grant_o,
  output logic [CH_W-1:0] grant_ch_o,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_ch_o,
  output logic            busy_o,
  output logic            store_o
);
  seq_state_e      state_q;
  logic [CH_W-1:0] active_q;
  logic            abort_q;
  logic            pick_valid;
  logic            live_cancel;

  adc_seq_pick #(.N(N_CH), .W(CH_W)) u_pick (
    .vec_i  (avail_i),
    .valid_o(pick_valid),
    .idx_o  (grant_ch_o)
  );

  assign grant_o      = (state_q == ST_IDLE) && pwr_en_i && pick_valid;
  assign live_cancel  = cancel_i[active_q];
  assign store_o      = (state_q == ST_BUSY) && conv_done_i && !abort_q && !live_cancel;
  assign conv_start_o = (state_q == ST_START);
  assign conv_ch_o    = active_q;
  assign busy_o       = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      active_q <= '0;
      abort_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (grant_o) begin
          state_q  <= ST_START;
          active_q <= grant_ch_o;
          abort_q  <= 1'b0;
        end
        ST_START: begin
          state_q <= ST_BUSY;
          if (live_cancel) abort_q <= 1'b1;
        end
        ST_BUSY: begin
          if (live_cancel) abort_q <= 1'b1;
          if (conv_done_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank #(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned RES_W = 12,
  parameter int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       store_i,
  input  logic [CH_W-1:0]            store_ch_i,
  input  logic [RES_W-1:0]           res_i,
  input  logic [N_CH-1:0]            clr_i,
  output logic [N_CH-1:0]            rdy_o,
  output logic [N_CH-1:0][RES_W-1:0] res_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hit;
    assign hit = store_i && (store_ch_i == CH_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdy_o[g] <= 1'b0;
        res_o[g] <= '0;
      end else if (clr_i[g]) begin
        rdy_o[g] <= 1'b0;
      end else if (hit) begin
        rdy_o[g] <= 1'b1;
        res_o[g] <= res_i;
      end
    end
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_CH   = adc_seq_pkg::NUM_CH,
  parameter int unsigned RES_W  = adc_seq_pkg::RES_W,
  parameter int unsigned CH_W   = $clog2(N_CH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  output logic                 conv_start_o,
  output logic [CH_W-1:0]      conv_ch_o,
  input  logic                 conv_done_i,
  input  logic [RES_W-1:0]     conv_res_i
);
  localparam int unsigned DATA_SPAN = 4 * N_CH;

  logic [BUS_W-1:0]            ctrl_q;
  logic [N_CH-1:0]             req_q, pend_q;
  logic                        pwr_q;
  logic                        req_wr;
  logic [N_CH-1:0]             rise_vec, fall_vec, grant_vec, avail;
  logic                        grant, ctrl_busy, store, stat_busy;
  logic [CH_W-1:0]             grant_ch;
  logic [N_CH-1:0]             rdy_vec;
  logic [N_CH-1:0][RES_W-1:0]  res_vec;
  logic [ADDR_W-1:0]           doff;
  logic                        data_hit;
  logic [CH_W-1:0]             data_idx;

  assign req_wr    = bus_we_i && (bus_addr_i == OFF_REQ);
  assign rise_vec  = req_wr ? (bus_wdata_i[N_CH-1:0] & ~req_q) : '0;
  assign fall_vec  = req_wr ? (~bus_wdata_i[N_CH-1:0] & req_q) : '0;
  assign grant_vec = grant ? (N_CH'(1) << grant_ch) : '0;
  // a channel cleared on this edge must not be granted on it
  assign avail     = pend_q & ~fall_vec;
  assign stat_busy = (|pend_q) || ctrl_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      req_q  <= '0;
      pend_q <= '0;
      pwr_q  <= 1'b0;
    end else begin
      if (bus_we_i && bus_addr_i == OFF_CTRL) ctrl_q <= bus_wdata_i;
      if (bus_we_i && bus_addr_i == OFF_PWR)  pwr_q  <= bus_wdata_i[PWR_BIT];
      if (req_wr) req_q <= bus_wdata_i[N_CH-1:0];
      pend_q <= (pend_q | rise_vec) & ~fall_vec & ~grant_vec;
    end
  end

  adc_seq_ctrl #(.N_CH(N_CH), .CH_W(CH_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_en_i    (pwr_q),
    .avail_i     (avail),
    .cancel_i    (fall_vec),
    .conv_done_i (conv_done_i),
    .grant_o     (grant),
    .grant_ch_o  (grant_ch),
    .conv_start_o(conv_start_o),
    .conv_ch_o   (conv_ch_o),
    .busy_o      (ctrl_busy),
    .store_o     (store)
  );

  adc_seq_bank #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .store_i   (store),
    .store_ch_i(conv_ch_o),
    .res_i     (conv_res_i),
    .clr_i     (fall_vec),
    .rdy_o     (rdy_vec),
    .res_o     (res_vec)
  );

  assign doff     = bus_addr_i - OFF_DATA;
  assign data_hit = (bus_addr_i >= OFF_DATA) && (32'(doff) < DATA_SPAN) && (doff[1:0] == 2'b00);
  assign data_idx = doff[CH_W+1:2];

  always_comb begin
    bus_rdata_o = '0;
    if (data_hit) begin
      bus_rdata_o[RES_W-1:0] = res_vec[data_idx];
      bus_rdata_o[RES_W]     = rdy_vec[data_idx];
    end else begin
      unique case (bus_addr_i)
        OFF_CTRL: bus_rdata_o = ctrl_q;
        OFF_REQ:  bus_rdata_o[N_CH-1:0] = req_q;
        OFF_STAT: bus_rdata_o[0] = stat_busy;
        OFF_PWR:  bus_rdata_o[PWR_BIT] = pwr_q;
        default:  bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned N_CH = 16,
  parameter int unsigned CH_W = $clog2(N_CH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            conv_start_o,
  input logic [CH_W-1:0] conv_ch_o,
  input logic            conv_done_i,
  input logic            pwr_q,
  input logic [N_CH-1:0] req_q,
  input logic [N_CH-1:0] rdy_vec,
  input logic [N_CH-1:0] fall_vec,
  input logic            stat_busy
);
  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_rdy_needs_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rdy_vec & ~$past(rdy_vec))) |-> $past(conv_done_i));

  assert_clear_drops_rdy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fall_vec) |=> ((rdy_vec & $past(fall_vec)) == '0));

  assert_start_has_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> req_q[conv_ch_o]);

  assert_busy_on_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> stat_busy);

  assert_start_needs_pwr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> pwr_q);
endmodule

bind adc_seq_regs adc_seq_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_start_o(conv_start_o),
  .conv_ch_o   (conv_ch_o),
  .conv_done_i (conv_done_i),
  .pwr_q       (pwr_q),
  .req_q       (req_q),
  .rdy_vec     (rdy_vec),
  .fall_vec    (fall_vec),
  .stat_busy   (stat_busy)
);

// File: tb/sim_adc_seq_regs.sv
module sim_adc_seq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        conv_start;
  logic [3:0]  conv_ch;
  logic        done = 1'b0;
  logic [11:0] res = '0;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int dly = 3;
  logic [11:0] last_res [16];
  bit finished = 0;

  localparam logic [7:0] A_CTRL = 8'h00, A_REQ = 8'h04, A_STAT = 8'h10, A_PWR = 8'h94;
  localparam logic [31:0] PWR_ON = 32'h0000_4000;

  always #10 clk = ~clk;

  adc_seq_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .conv_start_o(conv_start),
    .conv_ch_o(conv_ch), .conv_done_i(done), .conv_res_i(res)
  );

  function automatic logic [7:0] dat_a(input int ch);
    return 8'(8'h14 + 4 * ch);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 400; i++) begin
      rd(A_STAT, d);
      if (d[0] == 1'b0) break;
    end
  endtask

  // converter model and start monitor: pops the expected channel order
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (rst_n && conv_start) begin
        int ch;
        ch = int'(conv_ch);
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R4/R6/R9/R10: actual start on ch %0d expected none", ch);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk("R4 order", 32'(ch), 32'(e));
        end
        repeat (dly) @(negedge clk);
        cnt++;
        res = 12'((ch << 8) | (cnt & 8'hFF));
        last_res[ch] = res;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_REQ, d);  chk("R1 req", d, 0);
    rd(A_STAT, d); chk("R1 stat", d, 0);
    rd(dat_a(0), d); chk("R1 data0", d, 0);
    rd(A_PWR, d);  chk("R1 pwr", d, 0);
    chk("R1 start", 32'(conv_start), 0);

    // R11 readback
    wr(A_CTRL, 32'hCAFE_1234); rd(A_CTRL, d); chk("R11 ctrl", d, 32'hCAFE_1234);
    wr(A_PWR, 32'hFFFF_FFFF);  rd(A_PWR, d);  chk("R11 pwr", d, PWR_ON);

    // R2 start timing, R8 busy
    exp_q.push_back(3);
    wr(A_REQ, 32'h0000_0008);
    addr = A_STAT; #1;
    chk("R8 busy", rdata, 1);
    chk("R2 no start yet", 32'(conv_start), 0);
    @(negedge clk);
    chk("R2 start", 32'(conv_start), 1);
    chk("R2 ch", 32'(conv_ch), 3);
    @(negedge clk);
    chk("R2 pulse width", 32'(conv_start), 0);
    wait_idle();
    rd(A_STAT, d); chk("R8 idle", d, 0);
    rd(dat_a(3), d); chk("R3 result", d, {19'd0, 1'b1, last_res[3]});
    rd(A_REQ, d); chk("R11 req", d, 32'h8);

    // R5 clear drops ready, keeps data
    wr(A_REQ, 0);
    rd(dat_a(3), d); chk("R5 ready clear", d, {20'd0, last_res[3]});

    // R4 ascending order
    exp_q.push_back(2); exp_q.push_back(5); exp_q.push_back(9);
    wr(A_REQ, 32'h0000_0224);
    wait_idle();
    rd(dat_a(2), d); chk("R4 ch2", d, {19'd0, 1'b1, last_res[2]});
    rd(dat_a(5), d); chk("R4 ch5", d, {19'd0, 1'b1, last_res[5]});
    rd(dat_a(9), d); chk("R4 ch9", d, {19'd0, 1'b1, last_res[9]});

    // R10 ignored writes and no restart on held bit
    wr(A_REQ, 32'h0000_0224);
    repeat (10) @(negedge clk);
    wr(dat_a(2), 32'h0000_0000);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(dat_a(2), d); chk("R10 data write", d, {19'd0, 1'b1, last_res[2]});
    rd(A_STAT, d);   chk("R10 stat write", d, 0);

    // R6 cancel before start (power off), R9 hold
    wr(A_REQ, 0);
    wr(A_PWR, 0);
    wr(A_REQ, 32'h0000_0080);
    rd(A_STAT, d); chk("R8 pending busy", d, 1);
    repeat (20) @(negedge clk);
    wr(A_REQ, 0);
    rd(A_STAT, d); chk("R6 cancelled idle", d, 0);
    wr(A_PWR, PWR_ON);
    repeat (10) @(negedge clk);
    rd(dat_a(7), d); chk("R6 no result", d, 0);

    // R9 queued start waits for power
    wr(A_PWR, 0);
    exp_q.push_back(4);
    wr(A_REQ, 32'h0000_0010);
    repeat (10) @(negedge clk);
    rd(dat_a(4), d); chk("R9 held", d, 0);
    chk("R9 still queued", 32'(exp_q.size()), 1);
    wr(A_PWR, PWR_ON);
    wait_idle();
    rd(dat_a(4), d); chk("R9 released", d, {19'd0, 1'b1, last_res[4]});

    // R7 clear during conversion
    dly = 8;
    exp_q.push_back(6);
    wr(A_REQ, 32'h0000_0050);
    repeat (4) @(negedge clk);
    wr(A_REQ, 32'h0000_0010);
    wait_idle();
    repeat (12) @(negedge clk);
    rd(dat_a(6), d); chk("R7 discarded", d, 0);
    dly = 3;
    exp_q.push_back(6);
    wr(A_REQ, 32'h0000_0050);
    wait_idle();
    rd(dat_a(6), d); chk("R7 rearm", d, {19'd0, 1'b1, last_res[6]});
    rd(dat_a(4), d); chk("R10 ch4 untouched", d, {19'd0, 1'b1, last_res[4]});

    chk("R4 queue drained", 32'(exp_q.size()), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule